// File: doc/BRIEF.md
# Programmable Input Glitch Filter Bank

This block cleans up four asynchronous digital inputs before they reach a pulse-generator core. One input is an active-low fault-trip (emergency stop). The other three are position-sensor inputs. Each input is first brought into the peripheral clock domain by a two-flop synchroniser. It then passes through a digital noise canceller. The canceller discards any level change that does not persist for a programmable number of whole clock cycles.

The trip input and the sensor group each have their own 2-bit rejection-width select. The trip input has one filter enable. Each sensor input has its own enable bit. A disabled input reaches the output straight from its synchroniser. All filtering runs on the peripheral clock, so nothing is recognised while that clock is stopped.

The block carries no data stream. Every pin is a plain level-sensitive control or status signal, and none of them uses a handshake.

Top module: `incond_top`

## Requirements
- R1: The width select picks the rejection width N, with code 00 giving 4 cycles, 01 giving 8, 10 giving 16 and 11 giving 32. With the filter enabled, a level held for N-1 synchronised cycles never reaches the output. A level held for N or more cycles does reach it.
- R2: With the filter enabled, a filtered output takes a new level N+2 clock edges after the raw input changes: 2 synchroniser edges plus N filter edges. It returns to its idle level N+2 edges after the raw input returns.
- R3: When `trip_flt_en_i` is 0, `trip_n_o` equals the raw trip input delayed by exactly two clock edges, and pulses of any width pass.
- R4: Bit i of `sense_flt_en_i` routes sensor i (bit i of `sense_raw_i` and `sense_o`) through its filter when 1. When that bit is 0, sensor i is bypassed with a two-edge delay. The other sensors are not affected.
- R5: `trip_width_i` sets the width for the trip input only, and `sense_width_i` sets it for all three sensors only, so the two groups can use different widths at the same time.
- R6: While `rst_n` is low, `trip_n_o` is 1, `sense_o` is 000 and all filter counters are cleared.
- R7: A change of width select takes effect at the next clock edge and does not restart a count in progress. If the count already reaches the new width, the output toggles at that next edge.
- R8: Whenever the synchronised input equals the filtered output, the count returns to zero. Two N-1 pulses separated by a single idle cycle are therefore both rejected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_n_raw_i | input | 1 | Raw active-low fault-trip input |
| sense_raw_i | input | 3 | Raw position-sensor inputs |
| trip_flt_en_i | input | 1 | 1 filters the trip input, 0 bypasses it |
| trip_width_i | input | 2 | Trip rejection width select (00=4, 01=8, 10=16, 11=32) |
| sense_flt_en_i | input | 3 | Per-sensor filter enable, 1 filters |
| sense_width_i | input | 2 | Sensor-group rejection width select |
| trip_n_o | output | 1 | Conditioned active-low trip |
| sense_o | output | 3 | Conditioned sensor levels |

## Verification
The bench builds the block with its default parameters: two synchroniser stages and a 6-bit counter. With these values all four width codes, up to the 32-cycle width, can be exercised within a few hundred cycles per scenario. Each code is driven with N-1 and N+1 pulses, on both the trip input and each sensor, filtered and bypassed. The exact N+2 edge latency and the two-edge bypass latency are sampled edge by edge. The default counter width also leaves room to shrink the width select mid-count and to check that an interrupted count restarts from zero.

// File: rtl/incond_pkg.sv
package incond_pkg;
  typedef enum logic [1:0] {
    WSEL_4  = 2'b00,
    WSEL_8  = 2'b01,
    WSEL_16 = 2'b10,
    WSEL_32 = 2'b11
  } width_sel_t;

  // rejection width in whole clock cycles: 4 << code
  function automatic int unsigned width_cycles(width_sel_t s);
    return 32'd4 << s;
  endfunction
endpackage

// File: rtl/incond_sync.sv
module incond_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/incond_filter.sv
module incond_filter
  import incond_pkg::*;
#(
  parameter int   CNT_W   = 6,
  parameter logic RST_VAL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       d_i,      // already synchronised
  input  logic       en_i,
  input  width_sel_t width_i,
  output logic       q_o
);
  logic [CNT_W-1:0] cnt_q, cnt_inc, thr;
  logic             filt_q;

  assign thr     = CNT_W'(width_cycles(width_i));
  assign cnt_inc = cnt_q + 1'b1;

  // count cycles of disagreement; adopt the new level once the width is met
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      filt_q <= RST_VAL;
    end else if (d_i == filt_q) begin
      cnt_q  <= '0;
    end else if (cnt_inc >= thr) begin
      cnt_q  <= '0;
      filt_q <= d_i;
    end else begin
      cnt_q  <= cnt_inc;
    end
  end

  assign q_o = en_i ? filt_q : d_i;

  // a toggle of the filtered level needs a full count behind it
  assert_toggle_needs_count_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_q != $past(filt_q)) |-> (($past(cnt_q) + 1) >= $past(thr)));

  // agreement always clears the count
  assert_agree_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (d_i == filt_q) |=> (cnt_q == '0));

  // a count at or above a freshly lowered width is resolved on the next edge
  assert_shrunk_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q >= thr) |=> (cnt_q == '0));
endmodule

// File: rtl/incond_top.sv
module incond_top
  import incond_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 6,
  parameter int NUM_SENSE   = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 trip_n_raw_i,
  input  logic [NUM_SENSE-1:0] sense_raw_i,
  input  logic                 trip_flt_en_i,
  input  logic [1:0]           trip_width_i,
  input  logic [NUM_SENSE-1:0] sense_flt_en_i,
  input  logic [1:0]           sense_width_i,
  output logic                 trip_n_o,
  output logic [NUM_SENSE-1:0] sense_o
);
  logic                 trip_sync;
  logic [NUM_SENSE-1:0] sense_sync;

  // trip path: idle level is high (active low)
  incond_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_trip_sync (
    .clk(clk), .rst_n(rst_n), .d_i(trip_n_raw_i), .q_o(trip_sync));

  incond_filter #(.CNT_W(CNT_W), .RST_VAL(1'b1)) u_trip_flt (
    .clk(clk), .rst_n(rst_n), .d_i(trip_sync), .en_i(trip_flt_en_i),
    .width_i(width_sel_t'(trip_width_i)), .q_o(trip_n_o));

  // sensor paths: idle level is low, shared width, private enables
  for (genvar g = 0; g < NUM_SENSE; g++) begin : g_sense
    incond_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync (
      .clk(clk), .rst_n(rst_n), .d_i(sense_raw_i[g]), .q_o(sense_sync[g]));

    incond_filter #(.CNT_W(CNT_W), .RST_VAL(1'b0)) u_flt (
      .clk(clk), .rst_n(rst_n), .d_i(sense_sync[g]), .en_i(sense_flt_en_i[g]),
      .width_i(width_sel_t'(sense_width_i)), .q_o(sense_o[g]));
  end

  // cycles since reset, saturating, gates the delay check below
  logic [1:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  // bypassed trip follows the raw pin two edges late
  assert_bypass_delay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((warm_q >= 2'd2) && !trip_flt_en_i) |-> (trip_n_o == $past(trip_n_raw_i, 2)));
endmodule

// File: tb/incond_top_test.sv
module incond_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trip_n_raw = 1'b1;
  logic [2:0] sense_raw = 3'b000;
  logic       trip_en = 1'b1;
  logic [1:0] trip_w = 2'b00;
  logic [2:0] sense_en = 3'b111;
  logic [1:0] sense_w = 2'b00;
  logic       trip_n_o;
  logic [2:0] sense_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  incond_top uut (
    .clk(clk), .rst_n(rst_n), .trip_n_raw_i(trip_n_raw), .sense_raw_i(sense_raw),
    .trip_flt_en_i(trip_en), .trip_width_i(trip_w), .sense_flt_en_i(sense_en),
    .sense_width_i(sense_w), .trip_n_o(trip_n_o), .sense_o(sense_o));

  task automatic check(input logic got, input logic exp, input string req, input string what);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %0b expected %0b at %0t", req, what, got, exp, $time);
    end
  endtask

  // channel 0 = trip (active when low), 1..3 = sensors
  function automatic logic active_out(input int ch);
    return (ch == 0) ? ~trip_n_o : sense_o[ch-1];
  endfunction

  task automatic set_raw(input int ch, input logic act);
    if (ch == 0) trip_n_raw = ~act;
    else         sense_raw[ch-1] = act;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // R1/R2/R3/R4: one pulse of w cycles, sampled after every edge
  task automatic run_pulse(input int ch, input int w, input int sel, input bit en, input string req);
    int n = 4 << sel;
    bit pass = !en || (w >= n);
    int st = en ? n + 2 : 2;
    int en_ = en ? w + n + 2 : w + 2;
    if (ch == 0) begin trip_w = 2'(sel); trip_en = en; end
    else begin sense_w = 2'(sel); sense_en[ch-1] = en; end
    idle(2);
    set_raw(ch, 1'b1);
    for (int k = 1; k <= w + n + 4; k++) begin
      @(negedge clk);
      check(active_out(ch), pass && k >= st && k < en_, req,
            $sformatf("ch%0d w=%0d N=%0d en=%0b edge %0d", ch, w, n, en, k));
      if (k == w) set_raw(ch, 1'b0);
    end
    idle(4);
  endtask

  task automatic t_reset_R6;
    idle(3);
    check(trip_n_o, 1'b1, "R6", "trip idle in reset");
    check(sense_o[0], 1'b0, "R6", "sense0 in reset");
    check(sense_o[1], 1'b0, "R6", "sense1 in reset");
    check(sense_o[2], 1'b0, "R6", "sense2 in reset");
    rst_n = 1'b1;
    idle(4);
  endtask

  task automatic t_widths_R1_R2;
    for (int sel = 0; sel < 4; sel++) begin
      int n = 4 << sel;
      run_pulse(0, n - 1, sel, 1'b1, "R1");
      run_pulse(0, n + 1, sel, 1'b1, "R2");
      for (int ch = 1; ch <= 3; ch++) begin
        run_pulse(ch, n - 1, sel, 1'b1, "R1");
        run_pulse(ch, n + 1, sel, 1'b1, "R2");
      end
    end
    sense_en = 3'b111; trip_en = 1'b1;
  endtask

  task automatic t_bypass_R3;
    for (int sel = 0; sel < 4; sel++) begin
      int n = 4 << sel;
      run_pulse(0, n - 1, sel, 1'b0, "R3");
      run_pulse(0, 1, sel, 1'b0, "R3");
    end
    trip_en = 1'b1;
  endtask

  task automatic t_sense_enables_R4;
    for (int ch = 1; ch <= 3; ch++) run_pulse(ch, 3, 0, 1'b0, "R4");
    sense_en = 3'b010; sense_w = 2'b00;
    idle(2);
    sense_raw = 3'b111;
    idle(3);
    check(sense_o[0], 1'b1, "R4", "sense0 bypassed passes");
    check(sense_o[1], 1'b0, "R4", "sense1 filtered blocks 3-cycle pulse");
    check(sense_o[2], 1'b1, "R4", "sense2 bypassed passes");
    sense_raw = 3'b000;
    idle(8);
    check(sense_o[1], 1'b0, "R4", "sense1 stayed low");
    sense_en = 3'b111;
  endtask

  task automatic t_groups_R5;
    trip_en = 1'b1; sense_en = 3'b111;
    trip_w = 2'b00; sense_w = 2'b11;
    idle(2);
    trip_n_raw = 1'b0; sense_raw[0] = 1'b1;
    idle(6);
    trip_n_raw = 1'b1; sense_raw[0] = 1'b0;
    idle(2);
    check(trip_n_o, 1'b0, "R5", "trip with width 4 passes 6-cycle pulse");
    check(sense_o[0], 1'b0, "R5", "sensor with width 32 blocks 6-cycle pulse");
    idle(40);
    check(sense_o[0], 1'b0, "R5", "sensor never rose");
    check(trip_n_o, 1'b1, "R5", "trip back idle");
  endtask

  task automatic t_width_change_R7;
    sense_en = 3'b111; sense_w = 2'b11;
    idle(2);
    sense_raw[2] = 1'b1;
    idle(12);
    check(sense_o[2], 1'b0, "R7", "still counting at width 32");
    sense_w = 2'b00;
    idle(1);
    check(sense_o[2], 1'b1, "R7", "toggles on next edge after narrowing");
    sense_raw[2] = 1'b0;
    idle(10);
    check(sense_o[2], 1'b0, "R7", "returns low at width 4");
  endtask

  task automatic t_restart_R8;
    trip_en = 1'b1; trip_w = 2'b01;
    idle(2);
    trip_n_raw = 1'b0; idle(7);
    trip_n_raw = 1'b1; idle(1);
    trip_n_raw = 1'b0;
    for (int k = 0; k < 7; k++) begin
      @(negedge clk);
      check(trip_n_o, 1'b1, "R8", "split pulse rejected");
    end
    trip_n_raw = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      check(trip_n_o, 1'b1, "R8", "split pulse rejected tail");
    end
  endtask

  initial begin
    t_reset_R6;
    t_widths_R1_R2;
    t_bypass_R3;
    t_sense_enables_R4;
    t_groups_R5;
    t_width_change_R7;
    t_restart_R8;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule